// File: doc/BRIEF.md
# Shared External Interrupt Router

This block gathers a set of external interrupt lines and distributes them to several hart contexts, where a context is one privilege mode on one hardware thread. Every source passes through its own gateway, which turns a level or an edge into a single pending request. The block keeps one priority per source and one pending bit per source, and all contexts share them. Each context adds its own enable mask and its own priority threshold. Each context has a registered interrupt line that is high while at least one source is eligible for it.

Software in a context reads that context's claim register to get the best eligible source. The same read clears the source's pending bit and holds its gateway closed. When the handler is done, software writes the source ID back to the same register, which reopens the gateway. A level source that is still high then becomes pending again. An edge source waits for a fresh rising edge.

Configuration goes through a plain single-cycle request port, and read data returns one cycle after the request. Parameters set the source count (at most 31), the context count, the priority width and which sources are level-sensitive.

Top module: `ext_irq_router`

## Requirements
- R1: After reset, all priorities, enable masks, thresholds and pending bits are zero. irq_out is all zero and rsp_valid is low.
- R2: A context's line is raised only by sources whose enable bit is set for that context. The enable word of context c is at address {2'b10, 10'(c)}, and bit i of the word is source i.
- R3: A source is eligible for a context only if its priority is nonzero and at or above that context's threshold. Priority 0 never interrupts and never wins a claim. A source's priority is at {2'b00, 10'(id)}. The threshold of context c is at {2'b11, 9'(c), 1'b0}.
- R4: The claim winner is the eligible source with the highest priority. Among sources of equal priority, the lowest source ID wins.
- R5: A read of context c's claim register at {2'b11, 9'(c), 1'b1} returns the winning ID and clears that source's pending bit in the same access. When nothing is eligible it returns 0.
- R6: A claimed source cannot become pending again until its ID is written to the claim register of a context that has it enabled. A completion write from a context that does not have the source enabled is ignored.
- R7: After completion, a level source that is still high becomes pending again. An edge source needs a new rising edge, and an edge that arrives while the source is claimed is dropped.
- R8: irq_out is registered. It rises two clock edges after an input rises: one edge to set pending, one to update the line. It falls one edge after the claim edge.
- R9: A read request returns rsp_rdata with rsp_valid exactly one cycle later. The pending word is at {2'b01, 10'b0}, with bit i for source i and bit 0 always 0. Priority and threshold read back zero-extended.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_in | input | NSRC | Source lines, bit i is source i (1-based) |
| req_valid | input | 1 | Register request strobe |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 12 | Register address (region in bits 11:10) |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read data valid, one cycle after a read |
| rsp_rdata | output | 32 | Read data |
| irq_out | output | NCTX | Registered interrupt line per context |

## Verification
Suppose a gateway fails to clear on a claim or to stay closed while its source is in service. The next claim read from the same context then returns that ID again, so the fault shows within one register access. A wrong priority comparison or a wrong tie-break shows up as a wrong ID on the first claim over a mix of equal and unequal priorities. A stale pending or enable bit shows on irq_out two edges after the input or configuration changes. Random priorities, masks and levels are then checked against a bench model on every claim.

// File: rtl/irq_router_pkg.sv
package irq_router_pkg;

    localparam int ADDR_W = 12;
    localparam int DATA_W = 32;

    typedef enum logic [1:0] {
        RGN_PRIO = 2'd0,
        RGN_PEND = 2'd1,
        RGN_ENAB = 2'd2,
        RGN_CTX  = 2'd3
    } region_e;

    typedef struct packed {
        logic pending;
        logic busy;
        logic prev;
    } gw_state_t;

    function automatic int unsigned width_min1(input int unsigned n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/irq_gateway.sv
module irq_gateway
    import irq_router_pkg::*;
#(
    parameter bit LEVEL = 1'b1
) (
    input  logic clk,
    input  logic rst,
    input  logic src_in,
    input  logic claim,
    input  logic complete,
    output logic pending
);

    gw_state_t st;
    logic      trig;

    assign trig    = LEVEL ? src_in : (src_in & ~st.prev);
    assign pending = st.pending;

    always_ff @(posedge clk) begin
        if (rst) begin
            st <= '0;
        end else begin
            st.prev <= src_in;
            if (claim) begin
                st.pending <= 1'b0;
                st.busy    <= 1'b1;
            end else if (complete) begin
                st.busy <= 1'b0;
            end else if (!st.busy && !st.pending && trig) begin
                st.pending <= 1'b1;
            end
        end
    end

    // R5: a claim clears pending at the claim edge
    a_r5_claim_clears: assert property (@(posedge clk) disable iff (rst)
        claim |=> !pending);

    // R6: no new request while the source is in service
    a_r6_hold_in_service: assert property (@(posedge clk) disable iff (rst)
        (st.busy && !complete) |=> !pending);

    // R7: an edge source only becomes pending after its input was high
    a_r7_edge_needs_high: assert property (@(posedge clk) disable iff (rst)
        (!LEVEL && $rose(pending)) |-> $past(src_in));

endmodule

// File: rtl/irq_ctx_select.sv
module irq_ctx_select
    import irq_router_pkg::*;
#(
    parameter int NSRC   = 31,
    parameter int PRIO_W = 3,
    localparam int ID_W  = $clog2(NSRC + 1)
) (
    input  logic [NSRC:1]             pending,
    input  logic [NSRC:1]             enable,
    input  logic [NSRC:1][PRIO_W-1:0] prio,
    input  logic [PRIO_W-1:0]         thresh,
    output logic [ID_W-1:0]           best_id,
    output logic                      any_elig
);

    logic [PRIO_W-1:0] best_prio;
    logic [NSRC:1]     elig;

    always_comb begin
        for (int i = 1; i <= NSRC; i++) begin
            elig[i] = pending[i] && enable[i] && (prio[i] != '0) && (prio[i] >= thresh);
        end
    end

    // walk from the highest ID down so that an equal priority lets the lower ID take over
    always_comb begin
        best_id   = '0;
        best_prio = '0;
        any_elig  = 1'b0;
        for (int i = NSRC; i >= 1; i--) begin
            if (elig[i]) begin
                any_elig = 1'b1;
                if (prio[i] >= best_prio) begin
                    best_id   = ID_W'(i);
                    best_prio = prio[i];
                end
            end
        end
    end

endmodule

// File: rtl/irq_cfg_regs.sv
module irq_cfg_regs
    import irq_router_pkg::*;
#(
    parameter int NSRC   = 31,
    parameter int NCTX   = 2,
    parameter int PRIO_W = 3,
    localparam int ID_W  = $clog2(NSRC + 1)
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          req_valid,
    input  logic                          req_write,
    input  logic [ADDR_W-1:0]             req_addr,
    input  logic [DATA_W-1:0]             req_wdata,
    input  logic [NSRC:1]                 pending,
    input  logic [NCTX-1:0][ID_W-1:0]     best_id,
    output logic [NSRC:1][PRIO_W-1:0]     prio,
    output logic [NCTX-1:0][NSRC:1]       enable,
    output logic [NCTX-1:0][PRIO_W-1:0]   thresh,
    output logic [NSRC:1]                 claim_vec,
    output logic [NSRC:1]                 comp_vec,
    output logic                          rsp_valid,
    output logic [DATA_W-1:0]             rsp_rdata
);

    localparam int OFS_W = ADDR_W - 2;

    region_e           region;
    logic [OFS_W-1:0]  ofs;
    logic              rd_req;
    logic              wr_req;
    logic [DATA_W-1:0] rd_data;
    logic [NCTX-1:0]   ctx_hit;
    logic [NCTX-1:0]   enab_hit;

    assign region = region_e'(req_addr[ADDR_W-1:ADDR_W-2]);
    assign ofs    = req_addr[OFS_W-1:0];
    assign rd_req = req_valid && !req_write;
    assign wr_req = req_valid && req_write;

    always_comb begin
        for (int c = 0; c < NCTX; c++) begin
            ctx_hit[c]  = (region == RGN_CTX)  && (ofs[OFS_W-1:1] == (OFS_W-1)'(c));
            enab_hit[c] = (region == RGN_ENAB) && (ofs == OFS_W'(c));
        end
    end

    // read mux, claim strobes and completion strobes
    always_comb begin
        rd_data   = '0;
        claim_vec = '0;
        comp_vec  = '0;
        case (region)
            RGN_PRIO: begin
                for (int i = 1; i <= NSRC; i++) begin
                    if (ofs == OFS_W'(i)) rd_data = DATA_W'(prio[i]);
                end
            end
            RGN_PEND: begin
                for (int i = 1; i <= NSRC; i++) rd_data[i] = pending[i];
            end
            RGN_ENAB: begin
                for (int c = 0; c < NCTX; c++) begin
                    if (enab_hit[c]) begin
                        for (int i = 1; i <= NSRC; i++) rd_data[i] = enable[c][i];
                    end
                end
            end
            RGN_CTX: begin
                for (int c = 0; c < NCTX; c++) begin
                    if (ctx_hit[c]) begin
                        if (!ofs[0]) begin
                            rd_data = DATA_W'(thresh[c]);
                        end else begin
                            rd_data = DATA_W'(best_id[c]);
                            for (int i = 1; i <= NSRC; i++) begin
                                claim_vec[i] = rd_req && (best_id[c] == ID_W'(i));
                                comp_vec[i]  = wr_req && enable[c][i] &&
                                               (req_wdata == DATA_W'(i));
                            end
                        end
                    end
                end
            end
            default: rd_data = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            prio      <= '0;
            enable    <= '0;
            thresh    <= '0;
            rsp_valid <= 1'b0;
            rsp_rdata <= '0;
        end else begin
            rsp_valid <= rd_req;
            if (rd_req) rsp_rdata <= rd_data;
            if (wr_req) begin
                for (int i = 1; i <= NSRC; i++) begin
                    if (region == RGN_PRIO && ofs == OFS_W'(i))
                        prio[i] <= req_wdata[PRIO_W-1:0];
                end
                for (int c = 0; c < NCTX; c++) begin
                    if (enab_hit[c]) begin
                        for (int i = 1; i <= NSRC; i++) enable[c][i] <= req_wdata[i];
                    end
                    if (ctx_hit[c] && !ofs[0]) thresh[c] <= req_wdata[PRIO_W-1:0];
                end
            end
        end
    end

    // R5: a claim names exactly one source, and that source was pending
    a_r5_claim_pending: assert property (@(posedge clk) disable iff (rst)
        (claim_vec != '0) |-> ($onehot(claim_vec) && ((claim_vec & pending) == claim_vec)));

    // R6: a completion releases at most one gateway
    a_r6_one_release: assert property (@(posedge clk) disable iff (rst)
        $onehot0(comp_vec));

    // R9: read data follows a read request by one cycle
    a_r9_rsp_latency: assert property (@(posedge clk) disable iff (rst)
        rd_req |=> rsp_valid);

endmodule

// File: rtl/ext_irq_router.sv
module ext_irq_router
    import irq_router_pkg::*;
#(
    parameter int          NSRC       = 31,
    parameter int          NCTX       = 2,
    parameter int          PRIO_W     = 3,
    parameter logic [31:0] LEVEL_MASK = 32'h0001_FFFE
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [NSRC:1]     src_in,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [11:0]       req_addr,
    input  logic [31:0]       req_wdata,
    output logic              rsp_valid,
    output logic [31:0]       rsp_rdata,
    output logic [NCTX-1:0]   irq_out
);

    localparam int ID_W = $clog2(NSRC + 1);

    logic [NSRC:1]               pending;
    logic [NSRC:1]               claim_vec;
    logic [NSRC:1]               comp_vec;
    logic [NSRC:1][PRIO_W-1:0]   prio;
    logic [NCTX-1:0][NSRC:1]     enable;
    logic [NCTX-1:0][PRIO_W-1:0] thresh;
    logic [NCTX-1:0][ID_W-1:0]   best_id;
    logic [NCTX-1:0]             any_elig;
    logic [NCTX-1:0]             irq_q;

    for (genvar i = 1; i <= NSRC; i++) begin : g_src
        irq_gateway #(.LEVEL(LEVEL_MASK[i])) u_gw (
            .clk      (clk),
            .rst      (rst),
            .src_in   (src_in[i]),
            .claim    (claim_vec[i]),
            .complete (comp_vec[i]),
            .pending  (pending[i])
        );
    end

    for (genvar c = 0; c < NCTX; c++) begin : g_ctx
        irq_ctx_select #(.NSRC(NSRC), .PRIO_W(PRIO_W)) u_sel (
            .pending  (pending),
            .enable   (enable[c]),
            .prio     (prio),
            .thresh   (thresh[c]),
            .best_id  (best_id[c]),
            .any_elig (any_elig[c])
        );

        // R2: the line only rises when an enabled source was pending
        a_r2_line_needs_enabled: assert property (@(posedge clk) disable iff (rst)
            irq_q[c] |-> $past((pending & enable[c]) != '0));
    end

    irq_cfg_regs #(.NSRC(NSRC), .NCTX(NCTX), .PRIO_W(PRIO_W)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .req_valid (req_valid),
        .req_write (req_write),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .pending   (pending),
        .best_id   (best_id),
        .prio      (prio),
        .enable    (enable),
        .thresh    (thresh),
        .claim_vec (claim_vec),
        .comp_vec  (comp_vec),
        .rsp_valid (rsp_valid),
        .rsp_rdata (rsp_rdata)
    );

    always_ff @(posedge clk) begin
        if (rst) irq_q <= '0;
        else     irq_q <= any_elig;
    end

    assign irq_out = irq_q;

endmodule

// File: tb/ext_irq_router_tb.sv
module ext_irq_router_tb;

    localparam int NSRC = 31;
    localparam int NCTX = 2;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [NSRC:1]     src_in = '0;
    logic              req_valid = 1'b0;
    logic              req_write = 1'b0;
    logic [11:0]       req_addr = '0;
    logic [31:0]       req_wdata = '0;
    logic              rsp_valid;
    logic [31:0]       rsp_rdata;
    logic [NCTX-1:0]   irq_out;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    int m_prio [32];
    bit m_en   [2][32];
    int m_th   [2];
    bit m_pend [32];

    always #2 clk = ~clk;

    ext_irq_router u_dut (
        .clk(clk), .rst(rst), .src_in(src_in),
        .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .irq_out(irq_out)
    );

    function automatic logic [11:0] a_prio(input int id);  return {2'b00, 10'(id)}; endfunction
    function automatic logic [11:0] a_pend();               return {2'b01, 10'd0}; endfunction
    function automatic logic [11:0] a_enab(input int c);   return {2'b10, 10'(c)}; endfunction
    function automatic logic [11:0] a_thr(input int c);    return {2'b11, 9'(c), 1'b0}; endfunction
    function automatic logic [11:0] a_clm(input int c);    return {2'b11, 9'(c), 1'b1}; endfunction

    function automatic int best(input int c);
        int b = 0;
        int bp = 0;
        for (int i = NSRC; i >= 1; i--) begin
            if (m_pend[i] && m_en[c][i] && m_prio[i] != 0 && m_prio[i] >= m_th[c] && m_prio[i] >= bp) begin
                b  = i;
                bp = m_prio[i];
            end
        end
        return b;
    endfunction

    task automatic chk(input string req, input longint act, input longint exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] d);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b0; req_addr = a;
        @(negedge clk);
        req_valid = 1'b0;
        chk("R9 rsp_valid", rsp_valid, 1);
        d = rsp_rdata;
    endtask

    task automatic pulse(input int id);
        @(negedge clk); src_in[id] = 1'b1;
        @(negedge clk); src_in[id] = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; src_in = '0;
        step(3);
        rst = 1'b0;
        for (int i = 0; i < 32; i++) begin
            m_prio[i] = 0; m_pend[i] = 0; m_en[0][i] = 0; m_en[1][i] = 0;
        end
        m_th[0] = 0; m_th[1] = 0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        int unsigned seed_init;
        seed_init = $urandom(32'd1234);

        do_reset();
        // R1 reset state
        chk("R1 irq_out", irq_out, 0);
        chk("R1 rsp_valid", rsp_valid, 0);
        rd(a_prio(5), d);  chk("R1 prio5", d, 0);
        rd(a_pend(), d);   chk("R1 pending", d, 0);
        rd(a_thr(1), d);   chk("R1 thresh1", d, 0);
        rd(a_enab(0), d);  chk("R1 enable0", d, 0);
        rd(a_clm(0), d);   chk("R5 empty claim", d, 0);

        // R2 enable masks, R9 readback
        wr(a_prio(3), 2); wr(a_prio(5), 2); wr(a_prio(7), 5);
        wr(a_enab(0), (1 << 3) | (1 << 5));
        wr(a_enab(1), (1 << 7) | (1 << 20));
        @(negedge clk); src_in[3] = 1'b1; src_in[5] = 1'b1;
        step(3);
        chk("R2 irq ctx0", irq_out[0], 1);
        chk("R2 irq ctx1 masked", irq_out[1], 0);
        rd(a_pend(), d);  chk("R9 pending word", d, 32'h28);
        rd(a_prio(7), d); chk("R9 prio readback", d, 5);

        // R3 threshold, at-threshold counts
        wr(a_thr(0), 3); step(1);
        chk("R3 below threshold", irq_out[0], 0);
        rd(a_thr(0), d); chk("R9 thresh readback", d, 3);
        wr(a_thr(0), 2); step(1);
        chk("R3 at threshold", irq_out[0], 1);

        // R4 tie to lowest ID, R5 claim clears pending
        rd(a_clm(0), d); chk("R4 tie lowest id", d, 3);
        rd(a_pend(), d); chk("R5 pending cleared", d, 32'h20);
        rd(a_clm(0), d); chk("R4 next winner", d, 5);
        rd(a_clm(0), d); chk("R5 nothing left", d, 0);
        step(1);
        chk("R6 line low while claimed", irq_out[0], 0);
        rd(a_pend(), d); chk("R6 no re-pend before completion", d, 0);

        // R6 completion from wrong context ignored, R7 level re-pend
        wr(a_clm(1), 3); step(3);
        rd(a_pend(), d); chk("R6 foreign completion ignored", d, 0);
        @(negedge clk); src_in[5] = 1'b0;
        wr(a_clm(0), 3); wr(a_clm(0), 5); step(3);
        rd(a_pend(), d); chk("R7 level re-pend only if high", d, 32'h08);
        rd(a_clm(0), d); chk("R5 claim re-pended", d, 3);
        @(negedge clk); src_in[3] = 1'b0;
        wr(a_clm(0), 3); step(3);
        rd(a_pend(), d); chk("R7 level low stays idle", d, 0);

        // R7 edge source
        wr(a_prio(20), 4);
        pulse(20); step(2);
        rd(a_pend(), d); chk("R7 edge pends", d, 32'h0010_0000);
        chk("R2 irq ctx1 edge", irq_out[1], 1);
        rd(a_clm(1), d); chk("R5 claim edge src", d, 20);
        pulse(20); step(2);
        rd(a_clm(1), d); chk("R6 edge while claimed dropped", d, 0);
        wr(a_clm(1), 20); step(3);
        rd(a_pend(), d); chk("R7 edge needs new rise", d, 0);
        pulse(20); step(2);
        rd(a_pend(), d); chk("R7 new edge pends", d, 32'h0010_0000);

        // R3 priority zero
        wr(a_prio(20), 0); step(1);
        chk("R3 prio0 no irq", irq_out[1], 0);
        rd(a_clm(1), d); chk("R3 prio0 never claimed", d, 0);

        // R8 registered line timing
        @(negedge clk); src_in[7] = 1'b1;
        @(negedge clk); chk("R8 one edge after input", irq_out[1], 0);
        @(negedge clk); chk("R8 two edges after input", irq_out[1], 1);
        rd(a_clm(1), d); chk("R5 claim src7", d, 7);
        chk("R8 line at claim edge", irq_out[1], 1);
        @(negedge clk); chk("R8 line falls after claim", irq_out[1], 0);

        // random phase on level sources 1..16
        do_reset();
        for (int i = 1; i <= 16; i++) begin
            m_prio[i] = int'($urandom % 8);
            wr(a_prio(i), m_prio[i]);
        end
        for (int c = 0; c < 2; c++) begin
            logic [31:0] msk;
            msk = ($urandom & 32'hFFFF) << 1;
            for (int i = 1; i <= 16; i++) m_en[c][i] = msk[i];
            wr(a_enab(c), msk);
            m_th[c] = int'($urandom % 4);
            wr(a_thr(c), m_th[c]);
        end
        for (int it = 0; it < 300; it++) begin
            int c;
            int e;
            logic [15:0] lv;
            lv = 16'($urandom);
            @(negedge clk); src_in[16:1] = lv;
            step(3);
            for (int i = 1; i <= 16; i++) if (lv[i-1]) m_pend[i] = 1;
            chk("R2/R3 random irq ctx0", irq_out[0], best(0) != 0);
            chk("R2/R3 random irq ctx1", irq_out[1], best(1) != 0);
            c = int'($urandom % 2);
            e = best(c);
            rd(a_clm(c), d);
            chk("R4 random claim", d, e);
            if (e != 0) begin
                m_pend[e] = 0;
                wr(a_clm(c), e);
                step(3);
                if (src_in[e]) m_pend[e] = 1;
            end
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule